// File: doc/BRIEF.md
# Translation Lookaside Buffer Lookup with Access Control

This block is a small, fully associative translation buffer. Software loads its entries one at a time through a write port. Each entry carries a page number, a page size, an address-space bit, a process tag, a real page number and six permission bits. It can clear every entry at once through a global invalidate.

For each access the caller presents an access kind, the privilege level, the two address-space selectors and the process identifier, together with a 64-bit effective address. The block compares the resulting virtual address against every valid entry in parallel. Each compare ignores the address bits that fall inside that entry's page. One clock later the block returns one of two results:
- a hit, with the translated real address and the outcome of the permission check, or
- a miss, whose code tells an instruction fetch apart from a data access.

Top module: `tlb_lookup`

## Requirements
- R1: A request with `req_valid` high is answered exactly one clock later with `rsp_valid` high. In a cycle after a clock edge at which `req_valid` was low, `rsp_valid`, `rsp_hit`, `rsp_miss`, `rsp_multi`, `rsp_exc` and `rsp_ra` are all zero.
- R2: An entry matches when all four of these conditions hold:
  - the entry is valid;
  - its space bit equals `req_is` for a fetch or `req_ds` for any other kind;
  - its process tag is zero or equals `req_pid`;
  - its page number equals `req_ea[63:10]` on every bit at or above the page boundary.
  The request kind is encoded as 0 = fetch, 1 = load, 2 = store, 3 = load-class cache operation.
- R3: A size code k covers 4^k KB, so the page boundary sits at bit 10+2k. Codes above 10 act as 10 (1 GB). On a hit, `rsp_ra` takes its bits below the boundary from `req_ea` and its bits at and above the boundary from the entry's real page number, which holds real-address bits [43:10].
- R4: When no entry matches, the result is `rsp_miss` = 1, `rsp_hit` = 0 and `rsp_ra` = 0. `rsp_exc` is 1 for a fetch and 2 for any data kind.
- R5: A fetch hit is checked against permission bit 5 (user execute) when `req_pr` = 1 and against bit 4 (supervisor execute) when `req_pr` = 0. A cleared bit gives `rsp_exc` = 3.
- R6: A store hit is checked against bit 3 (user write) when `req_pr` = 1 and against bit 2 (supervisor write) when `req_pr` = 0. A cleared bit gives `rsp_exc` = 4.
- R7: A load or load-class cache operation hit is checked against bit 1 (user read) when `req_pr` = 1 and against bit 0 (supervisor read) when `req_pr` = 0. A cleared bit gives `rsp_exc` = 5. A permitted hit gives `rsp_exc` = 0.
- R8: When several entries match, the lowest-index entry supplies the address and the permissions, and `rsp_multi` is 1. `rsp_multi` is 0 otherwise.
- R9: With `wr_en` high, the entry at `wr_idx` takes every `wr_*` field at the clock edge. A request presented in the same cycle still sees the old contents.
- R10: `inv_all` clears every valid bit in one clock. A write in the same cycle still installs its own entry. Reset leaves every entry invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 3 | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_epn | input | 54 | Effective page number (address bits 63:10) |
| wr_ts | input | 1 | Address-space bit of the entry |
| wr_size | input | 4 | Page size code |
| wr_tid | input | 8 | Process tag, zero matches any process |
| wr_rpn | input | 34 | Real page number (real-address bits 43:10) |
| wr_perm | input | 6 | {UX,SX,UW,SW,UR,SR} |
| inv_all | input | 1 | Clear all valid bits |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store, 3 load-class cache operation |
| req_pr | input | 1 | Problem state (1 = user) |
| req_is | input | 1 | Instruction address-space selector |
| req_ds | input | 1 | Data address-space selector |
| req_pid | input | 8 | Current process identifier |
| req_ea | input | 64 | Effective address |
| rsp_valid | output | 1 | Response valid |
| rsp_hit | output | 1 | An entry matched |
| rsp_miss | output | 1 | No entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_exc | output | 3 | 0 none, 1 fetch miss, 2 data miss, 3 execute, 4 write, 5 read denial |
| rsp_ra | output | 44 | Real address |

## Verification
The bench targets the following corner cases; each entry names what a faulty design would do.
- **Largest page and clamped size codes.** A design that mis-sizes the offset would corrupt the low real-address bits, or would miss on addresses inside the page.
- **Process tag zero and the two space selectors.** Wrong space-bit selection would turn fetch hits into misses and data hits into misses, or the reverse. A design that did not treat a zero tag as a wildcard would miss on shared pages.
- **Overlapping entries.** These catch a design that picks the highest-index match or never raises the multi-hit flag.
- **Writes in the same cycle as a lookup or an invalidate.** These expose an entry array that forwards early, or an invalidate that wipes a fresh write.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int PAGE_LSB     = 10;   // smallest page is 1 KB
  localparam int MAX_SZ_CODE  = 10;   // 4^10 KB = 1 GB
  localparam int MAX_OFF_BITS = PAGE_LSB + 2 * MAX_SZ_CODE;

  // permission bit positions in an entry
  localparam int PB_SR = 0;
  localparam int PB_UR = 1;
  localparam int PB_SW = 2;
  localparam int PB_UW = 3;
  localparam int PB_SX = 4;
  localparam int PB_UX = 5;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_CLOAD = 2'd3
  } access_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_IMISS = 3'd1,
    EXC_DMISS = 3'd2,
    EXC_EXEC  = 3'd3,
    EXC_WRITE = 3'd4,
    EXC_READ  = 3'd5
  } exc_e;

  // number of effective-address bits that lie inside a page of this size
  function automatic int offset_bits(logic [3:0] sz);
    int k;
    k = (int'(sz) > MAX_SZ_CODE) ? MAX_SZ_CODE : int'(sz);
    return PAGE_LSB + 2 * k;
  endfunction

endpackage

// File: rtl/tlb_entry_match.sv
module tlb_entry_match
  import tlb_pkg::*;
#(
  parameter int EA_W  = 64,
  parameter int PID_W = 8
) (
  input  logic                     ent_valid,
  input  logic [EA_W-PAGE_LSB-1:0] ent_epn,
  input  logic                     ent_ts,
  input  logic [3:0]               ent_size,
  input  logic [PID_W-1:0]         ent_tid,
  input  logic                     as_bit,
  input  logic [PID_W-1:0]         pid,
  input  logic [EA_W-PAGE_LSB-1:0] ea_page,
  output logic                     hit
);

  localparam int EPN_W = EA_W - PAGE_LSB;

  // 1 on page-number bits that take part in the compare
  function automatic logic [EPN_W-1:0] care_mask(logic [3:0] sz);
    int ob;
    logic [EPN_W-1:0] m;
    ob = offset_bits(sz);
    for (int i = 0; i < EPN_W; i++) m[i] = ((i + PAGE_LSB) >= ob);
    return m;
  endfunction

  logic page_eq, tid_ok, space_ok;

  assign page_eq  = (((ea_page ^ ent_epn) & care_mask(ent_size)) == '0);
  assign tid_ok   = (ent_tid == '0) || (ent_tid == pid);
  assign space_ok = (ent_ts == as_bit);
  assign hit      = ent_valid & space_ok & tid_ok & page_eq;

endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check
  import tlb_pkg::*;
(
  input  access_e    kind,
  input  logic       pr,
  input  logic [5:0] perm,
  output logic       deny,
  output exc_e       code
);

  logic deny_x, deny_w, deny_r;

  assign deny_x = (kind == ACC_FETCH) && !(pr ? perm[PB_UX] : perm[PB_SX]);
  assign deny_w = (kind == ACC_STORE) && !(pr ? perm[PB_UW] : perm[PB_SW]);
  assign deny_r = ((kind == ACC_LOAD) || (kind == ACC_CLOAD)) &&
                  !(pr ? perm[PB_UR] : perm[PB_SR]);

  assign deny = deny_x | deny_w | deny_r;

  always_comb begin
    if (deny_x)      code = EXC_EXEC;
    else if (deny_w) code = EXC_WRITE;
    else if (deny_r) code = EXC_READ;
    else             code = EXC_NONE;
  end

  // R5 R6 R7: each access kind can raise at most one kind of denial
  always_comb begin
    a_r5_single_denial: assert ($onehot0({deny_x, deny_w, deny_r}));
  end

endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int N_ENTRIES = 8,
  parameter int EA_W      = 64,
  parameter int PID_W     = 8,
  parameter int RA_W      = 44
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [$clog2(N_ENTRIES)-1:0] wr_idx,
  input  logic                        wr_valid,
  input  logic [EA_W-11:0]            wr_epn,
  input  logic                        wr_ts,
  input  logic [3:0]                  wr_size,
  input  logic [PID_W-1:0]            wr_tid,
  input  logic [RA_W-11:0]            wr_rpn,
  input  logic [5:0]                  wr_perm,
  input  logic                        inv_all,
  input  logic                        req_valid,
  input  logic [1:0]                  req_kind,
  input  logic                        req_pr,
  input  logic                        req_is,
  input  logic                        req_ds,
  input  logic [PID_W-1:0]            req_pid,
  input  logic [EA_W-1:0]             req_ea,
  output logic                        rsp_valid,
  output logic                        rsp_hit,
  output logic                        rsp_miss,
  output logic                        rsp_multi,
  output logic [2:0]                  rsp_exc,
  output logic [RA_W-1:0]             rsp_ra
);

  localparam int IDX_W = $clog2(N_ENTRIES);
  localparam int EPN_W = EA_W - PAGE_LSB;
  localparam int RPN_W = RA_W - PAGE_LSB;

  // ---------------- entry storage ----------------
  logic [N_ENTRIES-1:0] valid_q;
  logic [EPN_W-1:0]     epn_q  [N_ENTRIES];
  logic                 ts_q   [N_ENTRIES];
  logic [3:0]           size_q [N_ENTRIES];
  logic [PID_W-1:0]     tid_q  [N_ENTRIES];
  logic [RPN_W-1:0]     rpn_q  [N_ENTRIES];
  logic [5:0]           perm_q [N_ENTRIES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      if (inv_all) valid_q <= '0;
      if (wr_en)   valid_q[wr_idx] <= wr_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      epn_q[wr_idx]  <= wr_epn;
      ts_q[wr_idx]   <= wr_ts;
      size_q[wr_idx] <= wr_size;
      tid_q[wr_idx]  <= wr_tid;
      rpn_q[wr_idx]  <= wr_rpn;
      perm_q[wr_idx] <= wr_perm;
    end
  end

  // ---------------- request decode ----------------
  access_e kind;
  logic    as_bit;

  assign kind   = access_e'(req_kind);
  assign as_bit = (kind == ACC_FETCH) ? req_is : req_ds;

  // ---------------- parallel compare ----------------
  logic [N_ENTRIES-1:0] hit_vec;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    tlb_entry_match #(
      .EA_W (EA_W),
      .PID_W(PID_W)
    ) u_match (
      .ent_valid(valid_q[g]),
      .ent_epn  (epn_q[g]),
      .ent_ts   (ts_q[g]),
      .ent_size (size_q[g]),
      .ent_tid  (tid_q[g]),
      .as_bit   (as_bit),
      .pid      (req_pid),
      .ea_page  (req_ea[EA_W-1:PAGE_LSB]),
      .hit      (hit_vec[g])
    );
  end

  // ---------------- selection ----------------
  function automatic logic several(logic [N_ENTRIES-1:0] v);
    return |(v & (v - 1'b1));
  endfunction

  logic [IDX_W-1:0] sel_idx;
  logic             any_hit;
  logic             multi_hit;

  always_comb begin
    sel_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (hit_vec[i]) sel_idx = IDX_W'(i);
    end
  end

  assign any_hit   = |hit_vec;
  assign multi_hit = several(hit_vec);

  // ---------------- address composition ----------------
  function automatic logic [RA_W-1:0] compose_ra(logic [RPN_W-1:0]        rpn,
                                                 logic [MAX_OFF_BITS-1:0] ea_lo,
                                                 logic [3:0]              sz);
    int ob;
    logic [RA_W-1:0] hi, lo, r;
    ob = offset_bits(sz);
    hi = {rpn, {PAGE_LSB{1'b0}}};
    lo = {{(RA_W-MAX_OFF_BITS){1'b0}}, ea_lo};
    for (int i = 0; i < RA_W; i++) r[i] = (i < ob) ? lo[i] : hi[i];
    return r;
  endfunction

  logic [RA_W-1:0] ra_c;
  assign ra_c = compose_ra(rpn_q[sel_idx], req_ea[MAX_OFF_BITS-1:0], size_q[sel_idx]);

  // ---------------- permission check ----------------
  logic perm_deny;
  exc_e perm_code;

  tlb_perm_check u_perm (
    .kind(kind),
    .pr  (req_pr),
    .perm(perm_q[sel_idx]),
    .deny(perm_deny),
    .code(perm_code)
  );

  exc_e miss_code;
  assign miss_code = (kind == ACC_FETCH) ? EXC_IMISS : EXC_DMISS;

  // ---------------- response register ----------------
  exc_e rsp_exc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_multi <= 1'b0;
      rsp_exc_q <= EXC_NONE;
      rsp_ra    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & any_hit;
      rsp_miss  <= req_valid & ~any_hit;
      rsp_multi <= req_valid & multi_hit;
      if (!req_valid)   rsp_exc_q <= EXC_NONE;
      else if (any_hit) rsp_exc_q <= perm_code;
      else              rsp_exc_q <= miss_code;
      rsp_ra <= (req_valid && any_hit) ? ra_c : '0;
    end
  end

  assign rsp_exc = rsp_exc_q;

  // ---------------- assertions ----------------
  a_r1_answer_next_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  a_r1_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !rsp_hit && !rsp_miss && !rsp_multi &&
                    rsp_exc == 3'd0 && rsp_ra == '0));

  a_r4_hit_or_miss: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_hit ^ rsp_miss));

  a_r4_miss_code: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> ((rsp_exc == 3'd1 || rsp_exc == 3'd2) && rsp_ra == '0));

  a_r8_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> rsp_hit);

  a_r10_invalidate_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (inv_all && !wr_en) |=> (valid_q == '0));

  a_r9_write_installs: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_valid) |=> valid_q[$past(wr_idx)]);

  // R2: a matching entry is always a valid one
  a_r2_hit_in_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_vec & ~valid_q) == '0);

endmodule

// File: tb/sim_tlb_lookup.sv
`timescale 1ns/1ps
module sim_tlb_lookup;

  localparam int N = 8, EA_W = 64, PID_W = 8, RA_W = 44;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en, wr_valid, wr_ts, inv_all, req_valid, req_pr, req_is, req_ds;
  logic [2:0] wr_idx;
  logic [53:0] wr_epn;
  logic [3:0] wr_size;
  logic [7:0] wr_tid, req_pid;
  logic [33:0] wr_rpn;
  logic [5:0] wr_perm;
  logic [1:0] req_kind;
  logic [63:0] req_ea;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_multi;
  logic [2:0] rsp_exc;
  logic [43:0] rsp_ra;

  always #2.5 clk = ~clk;

  tlb_lookup #(.N_ENTRIES(N), .EA_W(EA_W), .PID_W(PID_W), .RA_W(RA_W)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_epn(wr_epn), .wr_ts(wr_ts), .wr_size(wr_size), .wr_tid(wr_tid),
    .wr_rpn(wr_rpn), .wr_perm(wr_perm), .inv_all(inv_all), .req_valid(req_valid),
    .req_kind(req_kind), .req_pr(req_pr), .req_is(req_is), .req_ds(req_ds),
    .req_pid(req_pid), .req_ea(req_ea), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_miss(rsp_miss), .rsp_multi(rsp_multi), .rsp_exc(rsp_exc), .rsp_ra(rsp_ra));

  int vectors = 0, miscompares = 0;

  // behavioural reference model
  logic        m_v    [N];
  logic [63:0] m_page [N];
  logic        m_ts   [N];
  int          m_sz   [N];
  int          m_tid  [N];
  logic [63:0] m_real [N];
  logic [5:0]  m_perm [N];

  logic        e_valid, e_hit, e_miss, e_multi;
  logic [2:0]  e_exc;
  logic [43:0] e_ra;

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_eval();
    int nm, first, bit_no;
    logic [63:0] off_mask;
    logic as_sel;
    e_valid = 0; e_hit = 0; e_miss = 0; e_multi = 0; e_exc = 0; e_ra = 0;
    if (req_valid) begin
      e_valid = 1;
      as_sel = (req_kind == 2'd0) ? req_is : req_ds;
      nm = 0; first = -1;
      for (int i = 0; i < N; i++) begin
        off_mask = (64'd1 << (10 + 2 * ((m_sz[i] > 10) ? 10 : m_sz[i]))) - 64'd1;
        if (m_v[i] && m_ts[i] == as_sel && (m_tid[i] == 0 || m_tid[i] == int'(req_pid)) &&
            ((req_ea & ~off_mask) == (m_page[i] & ~off_mask))) begin
          nm++;
          if (first < 0) first = i;
        end
      end
      if (nm == 0) begin
        e_miss = 1;
        e_exc  = (req_kind == 2'd0) ? 3'd1 : 3'd2;
      end else begin
        e_hit   = 1;
        e_multi = (nm > 1);
        off_mask = (64'd1 << (10 + 2 * ((m_sz[first] > 10) ? 10 : m_sz[first]))) - 64'd1;
        e_ra = 44'((m_real[first] & ~off_mask) | (req_ea & off_mask));
        case (req_kind)
          2'd0:    bit_no = req_pr ? 5 : 4;
          2'd2:    bit_no = req_pr ? 3 : 2;
          default: bit_no = req_pr ? 1 : 0;
        endcase
        if (!m_perm[first][bit_no])
          e_exc = (req_kind == 2'd0) ? 3'd3 : (req_kind == 2'd2) ? 3'd4 : 3'd5;
      end
    end
  endtask

  task automatic model_update();
    if (inv_all) for (int i = 0; i < N; i++) m_v[i] = 0;
    if (wr_en) begin
      m_v[wr_idx]    = wr_valid;
      m_page[wr_idx] = {wr_epn, 10'b0};
      m_ts[wr_idx]   = wr_ts;
      m_sz[wr_idx]   = int'(wr_size);
      m_tid[wr_idx]  = int'(wr_tid);
      m_real[wr_idx] = {20'b0, wr_rpn, 10'b0};
      m_perm[wr_idx] = wr_perm;
    end
  endtask

  task automatic tick();
    model_eval();
    model_update();
    @(negedge clk);
    vectors++;
    chk("R1", "rsp_valid", 64'(rsp_valid), 64'(e_valid));
    chk("R2", "rsp_hit", 64'(rsp_hit), 64'(e_hit));
    chk("R4", "rsp_miss", 64'(rsp_miss), 64'(e_miss));
    chk("R8", "rsp_multi", 64'(rsp_multi), 64'(e_multi));
    chk("R5/R6/R7", "rsp_exc", 64'(rsp_exc), 64'(e_exc));
    chk("R3", "rsp_ra", 64'(rsp_ra), 64'(e_ra));
  endtask

  task automatic clr();
    wr_en = 0; wr_idx = 0; wr_valid = 0; wr_epn = 0; wr_ts = 0; wr_size = 0;
    wr_tid = 0; wr_rpn = 0; wr_perm = 0; inv_all = 0;
    req_valid = 0; req_kind = 0; req_pr = 0; req_is = 0; req_ds = 0; req_pid = 0; req_ea = 0;
  endtask

  task automatic set_wr(int idx, logic v, logic [63:0] va, logic ts, int sz, int tid,
                        logic [63:0] pa, logic [5:0] perm);
    wr_en = 1; wr_idx = 3'(idx); wr_valid = v; wr_epn = va[63:10]; wr_ts = ts;
    wr_size = 4'(sz); wr_tid = 8'(tid); wr_rpn = pa[43:10]; wr_perm = perm;
  endtask

  task automatic set_req(int kind, logic pr, logic is_b, logic ds_b, int pid, logic [63:0] ea);
    req_valid = 1; req_kind = 2'(kind); req_pr = pr; req_is = is_b; req_ds = ds_b;
    req_pid = 8'(pid); req_ea = ea;
  endtask

  task automatic put(int idx, logic [63:0] va, logic ts, int sz, int tid,
                     logic [63:0] pa, logic [5:0] perm);
    set_wr(idx, 1'b1, va, ts, sz, tid, pa, perm);
    tick(); clr();
  endtask

  task automatic ask(int kind, logic pr, logic is_b, logic ds_b, int pid, logic [63:0] ea);
    set_req(kind, pr, is_b, ds_b, pid, ea);
    tick(); clr();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  logic [63:0] pool [4];

  initial begin
    clr();
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_page[i] = 0; m_ts[i] = 0; m_sz[i] = 0;
      m_tid[i] = 0; m_real[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk);
    // R10: outputs quiet while in reset
    vectors++;
    chk("R10", "reset rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R10", "reset rsp_ra", 64'(rsp_ra), 64'd0);
    rst_n = 1;
    tick();
    // R10: nothing valid after reset, so fetch and data both miss (R4)
    ask(0, 0, 0, 0, 0, 64'h0);
    ask(1, 0, 0, 0, 0, 64'h0);

    // 4 KB page, tag 5, all rights
    put(0, 64'h0000_0012_3456_7000, 0, 1, 5, 64'h0000_0ABC_DE00_1000, 6'h3F);
    ask(0, 0, 0, 0, 5, 64'h0000_0012_3456_7123);   // R2 R3 fetch hit
    ask(1, 1, 1, 0, 5, 64'h0000_0012_3456_7FFF);   // R2 data uses ds
    ask(2, 1, 0, 0, 5, 64'h0000_0012_3456_7004);   // R6 store allowed
    ask(1, 0, 0, 0, 6, 64'h0000_0012_3456_7004);   // R2 pid mismatch -> miss
    ask(0, 0, 1, 0, 5, 64'h0000_0012_3456_7004);   // R2 space mismatch, R4 fetch miss
    ask(1, 0, 0, 0, 5, 64'h0000_0012_3456_8000);   // R2 next page -> data miss

    // 1 GB page, wildcard tag, space 1, supervisor read + execute only
    put(1, 64'h0000_0000_4000_0000, 1, 10, 0, 64'h0000_0C00_0000_0000, 6'b010001);
    ask(0, 0, 1, 0, 77, 64'h0000_0000_7ABC_DEF0); // R3 R5 supervisor fetch ok
    ask(0, 1, 1, 0, 9, 64'h0000_0000_4000_0010);  // R5 user fetch denied
    ask(1, 1, 0, 1, 9, 64'h0000_0000_4000_0010);  // R7 user load denied
    ask(3, 1, 0, 1, 9, 64'h0000_0000_4000_0010);  // R7 cache-load denied
    ask(3, 0, 0, 1, 9, 64'h0000_0000_4000_0010);  // R7 supervisor ok
    ask(2, 0, 0, 1, 9, 64'h0000_0000_5000_0010);  // R6 supervisor store denied

    // R3: size code 15 acts as 1 GB
    put(2, 64'h0000_0001_0000_0000, 0, 15, 0, 64'h0000_0200_0000_0000, 6'b101010);
    ask(1, 1, 0, 0, 1, 64'h0000_0001_3FFF_FFFC);  // R7 user read allowed
    ask(2, 0, 0, 0, 1, 64'h0000_0001_2000_0000);  // R6 supervisor write denied
    ask(0, 1, 0, 0, 1, 64'h0000_0001_0000_0100);  // R5 user execute allowed

    // R8: overlapping entries, lowest index wins
    put(5, 64'h0000_0000_8000_0000, 0, 2, 0, 64'h0000_0111_1111_0000, 6'h00);
    ask(1, 0, 0, 0, 3, 64'h0000_0000_8000_0ABC);
    put(3, 64'h0000_0000_8000_0000, 0, 2, 3, 64'h0000_0222_2222_0000, 6'h3F);
    ask(1, 0, 0, 0, 3, 64'h0000_0000_8000_0ABC);
    ask(1, 0, 0, 0, 4, 64'h0000_0000_8000_0ABC);

    // R9: lookup in the cycle of the write sees the old state
    set_wr(6, 1'b1, 64'h0000_00F0_0000_0000, 0, 0, 0, 64'h0000_0333_0000_0000, 6'h3F);
    set_req(1, 0, 0, 0, 0, 64'h0000_00F0_0000_0004);
    tick(); clr();
    ask(1, 0, 0, 0, 0, 64'h0000_00F0_0000_0004);  // R9 now hits
    // R9: writing valid=0 removes the entry
    set_wr(6, 1'b0, 64'h0000_00F0_0000_0000, 0, 0, 0, 64'h0, 6'h3F);
    tick(); clr();
    ask(1, 0, 0, 0, 0, 64'h0000_00F0_0000_0004);

    // R10: invalidate with a write to entry 4 in the same cycle
    set_wr(4, 1'b1, 64'h0000_0000_0000_0000, 0, 0, 0, 64'h0000_0444_0000_0000, 6'h3F);
    inv_all = 1;
    tick(); clr();
    ask(1, 0, 0, 0, 5, 64'h0000_0012_3456_7123);  // R10 old entry gone
    ask(0, 0, 0, 0, 0, 64'h0000_0000_0000_0200);  // R10 new entry survives

    // mixed traffic
    pool[0] = 64'h0000_0012_3456_7000;
    pool[1] = 64'h0000_0000_4000_0000;
    pool[2] = 64'h0000_0001_0000_0000;
    pool[3] = 64'h0000_0000_8000_0000;
    for (int n = 0; n < 3000; n++) begin
      int k;
      logic [63:0] r64;
      clr();
      k = int'($urandom % 4);
      r64 = {$urandom, $urandom};
      if ($urandom % 3 == 0)
        set_wr(int'($urandom % 8), 1'($urandom % 8 != 0), pool[k] ^ (r64 & 64'h0FFF_F000),
               1'($urandom), int'($urandom % 16), int'($urandom % 3), r64, 6'($urandom));
      inv_all = ($urandom % 97 == 0);
      if ($urandom % 4 != 0)
        set_req(int'($urandom % 4), 1'($urandom), 1'($urandom), 1'($urandom),
                int'($urandom % 3),
                pool[int'($urandom % 4)] ^ ({$urandom, $urandom} & 64'h0000_0000_03FF_FFFF));
      tick();
    end
    clr();
    tick();
    finish_run();
  end

endmodule